// File: doc/BRIEF.md
# Lock-Aware Glitch-Free Clock Source Selector

This block chooses which of two clocks feeds the audio output clock tree. One input is the clock recovered by a PLL. The other is a free-running crystal reference. The PLL clock is used whenever the PLL is running, reports lock and software has not pinned the output to the crystal. In every other case the crystal clock drives the output.

A request for the PLL source made while the PLL is unlocked is not acted on at once. It stays pending and takes effect by itself once lock arrives. Handovers caused by lock changes or by the force bit follow a break-before-make sequence. Each clock has its own gate, enabled on that clock's falling edge. The gate for the new clock opens only after the gate for the old clock has been seen closed, so the merged output never carries a shortened pulse.

Stopping the PLL oscillator, or entering low power, takes the PLL gate away at once. Continuity is given up in that case, and the crystal takes over. A status output names the active source. It changes only after a handover has completed.

Top module: `clk_src_select`

## Requirements
- R1: With force_xtal=0, pll_on=1 and low_power=0, raising pll_lock makes the PLL clock the output source. active_pll reads 1 within 60 crystal cycles, and clk_out then has the PLL clock's period.
- R2: With force_xtal=1 the crystal clock is the source, and active_pll=0, whether or not pll_lock is high.
- R3: Clearing force_xtal while pll_lock=0 leaves the crystal as the source. The switch to the PLL happens by itself once pll_lock rises.
- R4: Losing lock while on the PLL returns the output to the crystal clock, and active_pll goes to 0.
- R5: With pll_on=0 the crystal is the source even when pll_lock=1. Turning the PLL off while the crystal is already the source does not disturb clk_out.
- R6: With low_power=1 the crystal is the source even when pll_lock=1.
- R7: Switches caused by lock or force_xtal never put a high or low pulse on clk_out that is shorter than the shorter half-period of the two input clocks.
- R8: The PLL gate and the crystal gate are never open at the same time.
- R9: active_pll rises only after the crystal gate has closed. From that point clk_out carries the PLL period.
- R10: Turning the PLL off, or entering low power, while it is the source closes the PLL gate without waiting for a PLL clock edge. Continuity is not guaranteed, and the crystal becomes the source within 60 crystal cycles.
- R11: While rst_n=0, clk_out is low and active_pll=0. After reset the crystal is the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Recovered PLL clock; may stop when the PLL is off |
| clk_xtal | input | 1 | Crystal reference clock; always running |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock | input | 1 | PLL lock indication, asynchronous |
| force_xtal | input | 1 | 1 pins the output to the crystal clock, asynchronous |
| pll_on | input | 1 | 1 while the PLL oscillator runs, asynchronous |
| low_power | input | 1 | 1 selects low-power mode, which stops the PLL path, asynchronous |
| clk_out | output | 1 | Selected master clock |
| active_pll | output | 1 | 1 while the PLL clock drives clk_out after a completed handover |

## Verification
The assertions assume that the crystal clock runs without pause. They also assume that the PLL clock runs whenever pll_on=1 and low_power=0, and that each control input holds still for longer than a synchronizer chain, so that the handshake can finish. The stimulus holds every control level for 60 crystal cycles before it looks at the result. It stops the PLL clock only at the same instant it drops pll_on or raises low_power. The pulse-width monitor is suspended only across those abrupt-stop windows, where a runt is allowed.

// File: rtl/ckmux_pkg.sv
`timescale 1ns/1ps
package ckmux_pkg;

  typedef enum logic [1:0] {
    ST_XTAL    = 2'd0,
    ST_TO_PLL  = 2'd1,
    ST_PLL     = 2'd2,
    ST_TO_XTAL = 2'd3
  } ckmux_state_e;

  // PLL path usable only when the oscillator runs and low power is off
  function automatic logic pll_running(input logic osc_on, input logic low_pwr);
    return osc_on & ~low_pwr;
  endfunction

  // PLL source wanted: locked, not forced to crystal, oscillator running
  function automatic logic pll_wanted(input logic locked, input logic forced_xtal,
                                      input logic running);
    return locked & ~forced_xtal & running;
  endfunction

  function automatic ckmux_state_e next_state(input ckmux_state_e cur,
                                              input logic want,
                                              input logic kill,
                                              input logic pll_gate_seen,
                                              input logic xtal_gate);
    ckmux_state_e nxt;
    nxt = cur;
    case (cur)
      ST_XTAL:    if (want) nxt = ST_TO_PLL;
      ST_TO_PLL:  if (kill) nxt = ST_TO_XTAL;
                  else if (pll_gate_seen && !xtal_gate) nxt = ST_PLL;
      ST_PLL:     if (!want) nxt = ST_TO_XTAL;
      ST_TO_XTAL: if (xtal_gate && !pll_gate_seen) nxt = ST_XTAL;
      default:    nxt = ST_XTAL;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/ckmux_sync.sv
`timescale 1ns/1ps
module ckmux_sync #(
  parameter int STAGES    = 2,
  parameter int WIDTH     = 1,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ckmux_leg.sv
`timescale 1ns/1ps
module ckmux_leg #(
  parameter int STAGES = 2
) (
  input  logic clk_src,
  input  logic arst_n,
  input  logic req,
  output logic gate_en,
  output logic clk_gated
);
  // enable moves only on the falling edge, while clk_src is low
  ckmux_sync #(.STAGES(STAGES), .WIDTH(1), .FALL_EDGE(1'b1)) u_en_sync (
    .clk    (clk_src),
    .arst_n (arst_n),
    .d      (req),
    .q      (gate_en)
  );

  assign clk_gated = clk_src & gate_en;
endmodule

// File: rtl/ckmux_ctrl.sv
`timescale 1ns/1ps
module ckmux_ctrl
  import ckmux_pkg::*;
(
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic lock_s,
  input  logic force_s,
  input  logic on_s,
  input  logic lp_s,
  input  logic pll_gate_seen,
  input  logic xtal_gate,
  output logic sel_pll,
  output logic pll_kill,
  output logic active_pll
);
  ckmux_state_e st_q, st_d;
  logic running, want;

  assign running = pll_running(on_s, lp_s);
  assign want    = pll_wanted(lock_s, force_s, running);
  assign st_d    = next_state(st_q, want, pll_kill, pll_gate_seen, xtal_gate);

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_XTAL;
      pll_kill <= 1'b0;
    end else begin
      st_q     <= st_d;
      pll_kill <= ~running;
    end
  end

  assign sel_pll    = (st_q == ST_TO_PLL) || (st_q == ST_PLL);
  assign active_pll = (st_q == ST_PLL);

  // R2: a forced crystal selection keeps the crystal state
  assert_force_holds_xtal_R2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (st_q == ST_XTAL && force_s) |=> (st_q == ST_XTAL));

  // R4: lock loss starts the return handover
  assert_lockloss_leaves_R4: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (st_q == ST_PLL && !lock_s) |=> (st_q == ST_TO_XTAL));

  // R3: no move toward the PLL without lock
  assert_pending_until_lock_R3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (st_q == ST_XTAL && !lock_s) |=> (st_q == ST_XTAL));
endmodule

// File: rtl/clk_src_select.sv
`timescale 1ns/1ps
module clk_src_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_pll,
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic pll_lock,
  input  logic force_xtal,
  input  logic pll_on,
  input  logic low_power,
  output logic clk_out,
  output logic active_pll
);
  localparam int NUM_CTL = 4;

  logic [NUM_CTL-1:0] ctl_s;
  logic pll_en, xtal_en, pll_en_seen;
  logic sel_pll, pll_kill;
  logic pll_req, xtal_req, pll_arst_n;
  logic pll_gclk, xtal_gclk;

  ckmux_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_CTL), .FALL_EDGE(1'b0)) u_ctl_sync (
    .clk    (clk_xtal),
    .arst_n (rst_n),
    .d      ({pll_lock, force_xtal, pll_on, low_power}),
    .q      (ctl_s)
  );

  ckmux_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .FALL_EDGE(1'b0)) u_back_sync (
    .clk    (clk_xtal),
    .arst_n (rst_n),
    .d      (pll_en),
    .q      (pll_en_seen)
  );

  ckmux_ctrl u_ctrl (
    .clk_xtal      (clk_xtal),
    .rst_n         (rst_n),
    .lock_s        (ctl_s[3]),
    .force_s       (ctl_s[2]),
    .on_s          (ctl_s[1]),
    .lp_s          (ctl_s[0]),
    .pll_gate_seen (pll_en_seen),
    .xtal_gate     (xtal_en),
    .sel_pll       (sel_pll),
    .pll_kill      (pll_kill),
    .active_pll    (active_pll)
  );

  // break-before-make: each leg waits for the other gate to be closed
  assign pll_req    = sel_pll & ~xtal_en;
  assign xtal_req   = ~sel_pll & ~pll_en;
  assign pll_arst_n = rst_n & ~pll_kill;

  ckmux_leg #(.STAGES(SYNC_STAGES)) u_pll_leg (
    .clk_src   (clk_pll),
    .arst_n    (pll_arst_n),
    .req       (pll_req),
    .gate_en   (pll_en),
    .clk_gated (pll_gclk)
  );

  ckmux_leg #(.STAGES(SYNC_STAGES)) u_xtal_leg (
    .clk_src   (clk_xtal),
    .arst_n    (rst_n),
    .req       (xtal_req),
    .gate_en   (xtal_en),
    .clk_gated (xtal_gclk)
  );

  assign clk_out = pll_gclk | xtal_gclk;

  // R8: the two gates are exclusive
  assert_gates_exclusive_R8: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !(pll_en && xtal_en));

  // R9: status high only with the crystal gate closed
  assert_status_after_close_R9: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    active_pll |-> !xtal_en);

  // R10: a stopped PLL has its gate cleared without a PLL edge
  assert_kill_clears_gate_R10: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    pll_kill |-> !pll_en);
endmodule

// File: tb/clk_src_select_tb_top.sv
`timescale 1ns/1ps
module clk_src_select_tb_top;
  logic clk_pll = 1'b0, clk_xtal = 1'b0, rst_n = 1'b0;
  logic pll_lock = 1'b0, force_xtal = 1'b0, pll_on = 1'b1, low_power = 1'b0;
  logic clk_out, active_pll;
  logic pll_gen_on = 1'b1;

  int total = 0, bad = 0, runts = 0;
  bit mon_en = 1'b0, prev_ok = 1'b0, done = 1'b0;
  realtime last_edge = 0.0;

  localparam real XTAL_P = 8.0;
  localparam real PLL_P  = 6.0;
  localparam real MIN_HALF = 2.9;

  always #4 clk_xtal = ~clk_xtal;
  always begin
    #3;
    if (pll_gen_on) clk_pll = ~clk_pll;
  end

  clk_src_select dut_i (
    .clk_pll(clk_pll), .clk_xtal(clk_xtal), .rst_n(rst_n),
    .pll_lock(pll_lock), .force_xtal(force_xtal), .pll_on(pll_on),
    .low_power(low_power), .clk_out(clk_out), .active_pll(active_pll)
  );

  // R7 pulse-width monitor
  always @(clk_out) begin
    if (mon_en && prev_ok && ($realtime - last_edge) < MIN_HALF) runts++;
    prev_ok   = mon_en;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic xwait(input int n);
    repeat (n) @(posedge clk_xtal);
    #1;
  endtask

  task automatic get_period(output real p);
    realtime t0;
    @(posedge clk_out);
    t0 = $realtime;
    @(posedge clk_out);
    p = $realtime - t0;
  endtask

  task automatic chk_src(input string req, input bit exp_pll);
    real p, ep;
    ep = exp_pll ? PLL_P : XTAL_P;
    chk(active_pll === exp_pll, req, "active_pll", real'(active_pll), real'(exp_pll));
    get_period(p);
    chk((p > ep - 0.5) && (p < ep + 0.5), req, "clk_out period", p, ep);
    #1;
  endtask

  task automatic t_reset;
    #21;
    chk(clk_out === 1'b0, "R11", "clk_out in reset", real'(clk_out), 0.0);
    chk(active_pll === 1'b0, "R11", "active_pll in reset", real'(active_pll), 0.0);
    rst_n = 1'b1;
    xwait(60);
    chk_src("R11", 1'b0);
    mon_en = 1'b1;
  endtask

  task automatic t_lock_switch;
    real p;
    pll_lock = 1'b1;
    @(posedge active_pll);
    get_period(p);
    chk((p > PLL_P - 0.5) && (p < PLL_P + 0.5), "R9", "period right after status", p, PLL_P);
    xwait(60);
    chk_src("R1", 1'b1);
  endtask

  task automatic t_force;
    force_xtal = 1'b1;
    xwait(60);
    chk_src("R2", 1'b0);
  endtask

  task automatic t_pending;
    pll_lock = 1'b0;
    xwait(10);
    force_xtal = 1'b0;
    xwait(60);
    chk_src("R3", 1'b0);
    pll_lock = 1'b1;
    xwait(60);
    chk_src("R3", 1'b1);
  endtask

  task automatic t_lockloss;
    pll_lock = 1'b0;
    xwait(60);
    chk_src("R4", 1'b0);
    pll_lock = 1'b1;
    xwait(60);
    chk_src("R1", 1'b1);
  endtask

  task automatic t_disable;
    force_xtal = 1'b1;
    xwait(60);
    pll_on = 1'b0;
    xwait(10);
    force_xtal = 1'b0;
    xwait(60);
    chk_src("R5", 1'b0);
    pll_on = 1'b1;
    xwait(60);
    chk_src("R5", 1'b1);
  endtask

  task automatic t_abrupt(input bit use_lp);
    string rq;
    rq = use_lp ? "R6" : "R10";
    mon_en = 1'b0;
    if (use_lp) low_power = 1'b1; else pll_on = 1'b0;
    pll_gen_on = 1'b0;
    xwait(60);
    chk_src(rq, 1'b0);
    pll_gen_on = 1'b1;
    low_power = 1'b0;
    pll_on = 1'b1;
    xwait(60);
    chk_src(rq, 1'b1);
    mon_en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_lock_switch();
    t_force();
    t_pending();
    t_lockloss();
    t_disable();
    t_abrupt(1'b0);
    t_abrupt(1'b1);
    t_force();
    chk(runts == 0, "R7", "runt pulses on clean switches", real'(runts), 0.0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all): actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule